// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit effective address from up to three terms: a base register value, an index register value shifted left by a scale of 1, 2, 4 or 8, and a signed 32-bit displacement. Each register term can be switched off on its own. This lets one adder cover five forms: displacement only, base only, base with displacement, base with scaled index, and all three terms together. Register file reads are modelled as plain value inputs. All arithmetic wraps modulo 2^64.

The same sum can be used in two ways. It can drive a memory request as an address. It can also be returned as an arithmetic value for a load-effective-address operation, in which case no memory request is raised. A narrow variant of that value keeps only the low 32 bits and clears the rest. The block also checks operand legality: a request that names memory as both its source and its destination is flagged illegal, and it then raises neither a memory request nor a write-back.

Every result is registered. It appears with a valid strobe one clock after the valid input.

Top module: `ea_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `mem_req`, `wb_en` and `illegal` are all 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0.
- R3: `ea_addr` equals disp (sign-extended from 32 bits) + base + (index << scale_code), taken modulo 2^64. A `scale_code` of 0, 1, 2 or 3 multiplies the index by 1, 2, 4 or 8.
- R4: When `base_en` = 0 the base term is zero. When `index_en` = 0 the index term is zero. With both at 0 the address is the sign-extended displacement alone.
- R5: A displacement with bit 31 set is treated as negative and wraps correctly in two's complement. For example, -16 + base + index*4 gives the expected 64-bit value.
- R6: With `op_lea` = 0 and a legal request, `mem_req` = 1 and `wb_en` = 0. With `op_lea` = 1 and a legal request, `mem_req` = 0 and `wb_en` = 1. With `op_lea` = 1 and `op_narrow` = 0, `wb_value` equals the full address.
- R7: With `op_lea` = 1 and `op_narrow` = 1, `wb_value` bits 63:32 are 0 and bits 31:0 equal the low 32 bits of the address. For example, base = index = x, scale code 3 and displacement 1 give 9x+1 truncated to 32 bits.
- R8: When `src_mem` = 1 and `dst_mem` = 1, `illegal` = 1 and both `mem_req` and `wb_en` are 0. Otherwise `illegal` = 0.
- R9: While `out_valid` = 0, the outputs `mem_req`, `wb_en` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| base_en | input | 1 | Include the base term |
| base_val | input | 64 | Base register value |
| index_en | input | 1 | Include the index term |
| index_val | input | 64 | Index register value |
| scale_code | input | 2 | Index left shift, 0 to 3 |
| disp | input | 32 | Signed displacement |
| op_lea | input | 1 | Return the address as a value instead of accessing memory |
| op_narrow | input | 1 | 32-bit value variant: clear bits 63:32 |
| src_mem | input | 1 | Source operand is in memory |
| dst_mem | input | 1 | Destination operand is in memory |
| out_valid | output | 1 | Registered result valid |
| ea_addr | output | 64 | Full effective address |
| mem_req | output | 1 | Memory access requested with `ea_addr` |
| wb_en | output | 1 | Write `wb_value` to the destination register |
| wb_value | output | 64 | Address as an arithmetic result |
| illegal | output | 1 | Memory-to-memory combination rejected |

## Verification
Two functions can meet in the same cycle: the narrow value truncation and the illegal-combination rejection. The sweep drives every pairing of `op_lea`, `op_narrow`, `src_mem` and `dst_mem` against every scale code and every base/index enable pattern, so the narrow variant is requested both with and without an illegal operand pairing. In each case the bench checks that rejection suppresses the write-back strobe while `ea_addr` and `wb_value` still carry the computed sum. It also checks that the narrow result keeps only the low 32 bits of a sum whose upper bits are nonzero.

// File: rtl/ea_gen_pkg.sv
// Package: shared control type for the effective address generator.
// Assumes the three control outcomes travel together through one register stage.
package ea_gen_pkg;

    // Per-request outcome produced by the decode stage
    typedef struct packed {
        logic mem_req;
        logic wb_en;
        logic illegal;
    } ea_ctl_t;

endpackage

// File: rtl/ea_index_scaler.sv
// Module: ea_index_scaler
// Gates the index term and shifts it left by the scale code.
// Assumes the scale is a power of two selected by a SCALE_W-bit code, so a
// shift mux replaces a multiplier.
module ea_index_scaler #(
    parameter int ADDR_W  = 64,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  idx_i,
    input  logic               idx_en_i,
    input  logic [SCALE_W-1:0] code_i,
    output logic [ADDR_W-1:0]  scaled_o
);
    localparam int NUM_SH = 1 << SCALE_W;

    logic [ADDR_W-1:0] gated;
    logic [ADDR_W-1:0] cand [NUM_SH];

    // Zero the index when the form has no index register
    assign gated = idx_en_i ? idx_i : '0;

    // One candidate per legal shift amount
    for (genvar g = 0; g < NUM_SH; g++) begin : g_shift
        assign cand[g] = gated << g;
    end

    // Pick the candidate named by the code
    assign scaled_o = cand[code_i];
endmodule

// File: rtl/ea_sum3.sv
// Module: ea_sum3
// Adds the sign-extended displacement, the gated base and the scaled index.
// Assumes DISP_W < ADDR_W and that the sum wraps modulo 2^ADDR_W.
module ea_sum3 #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_en_i,
    input  logic [ADDR_W-1:0] scaled_idx_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] sum_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base_term;

    // Replicate the displacement sign bit into the upper bits
    assign disp_ext  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

    // Zero the base when the form has no base register
    assign base_term = base_en_i ? base_i : '0;

    // Single three-input add
    assign sum_o = disp_ext + base_term + scaled_idx_i;
endmodule

// File: rtl/ea_ctl_decode.sv
// Module: ea_ctl_decode
// Decides between memory request and value write-back, and rejects a
// request whose source and destination are both memory.
// Assumes a rejected request produces neither strobe.
module ea_ctl_decode
    import ea_gen_pkg::*;
(
    input  logic    op_lea_i,
    input  logic    src_mem_i,
    input  logic    dst_mem_i,
    output ea_ctl_t ctl_o
);
    // Combine the operand locations into the outcome flags
    always_comb begin
        ctl_o.illegal = src_mem_i & dst_mem_i;
        ctl_o.mem_req = ~op_lea_i & ~ctl_o.illegal;
        ctl_o.wb_en   = op_lea_i & ~ctl_o.illegal;
    end
endmodule

// File: rtl/ea_out_stage.sv
// Module: ea_out_stage
// Registers the address, the value result and the control flags.
// Flags are qualified by the valid input. Data registers hold their last
// values between requests. The narrow variant keeps NARROW_W low bits.
module ea_out_stage
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [ADDR_W-1:0] sum_i,
    input  logic              narrow_i,
    input  ea_ctl_t           ctl_i,
    output logic              out_valid_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] value_o,
    output ea_ctl_t           ctl_o
);
    localparam int HI_W = ADDR_W - NARROW_W;

    logic [ADDR_W-1:0] value_nxt;

    // Clear the upper bits for the narrow value form
    assign value_nxt = narrow_i ? {{HI_W{1'b0}}, sum_i[NARROW_W-1:0]} : sum_i;

    // Valid strobe and qualified flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            ctl_o       <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            ctl_o       <= in_valid_i ? ctl_i : '0;
        end
    end

    // Data capture on each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o    <= '0;
            value_o <= '0;
        end else if (in_valid_i) begin
            ea_o    <= sum_i;
            value_o <= value_nxt;
        end
    end
endmodule

// File: rtl/ea_addr_gen.sv
// Module: ea_addr_gen (top)
// Effective address generator: base + (index << scale) + sign-extended
// displacement, as a memory address or as a load-effective-address value.
// Assumes register reads arrive as values; one cycle of latency.
module ea_addr_gen
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DISP_W   = 32,
    parameter int SCALE_W  = 2,
    parameter int NARROW_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               base_en,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               index_en,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [DISP_W-1:0]  disp,
    input  logic               op_lea,
    input  logic               op_narrow,
    input  logic               src_mem,
    input  logic               dst_mem,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  ea_addr,
    output logic               mem_req,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_value,
    output logic               illegal
);
    logic [ADDR_W-1:0] scaled_idx;
    logic [ADDR_W-1:0] sum;
    ea_ctl_t           ctl_d;
    ea_ctl_t           ctl_q;

    // Index gate and shift
    ea_index_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
        .idx_i    (index_val),
        .idx_en_i (index_en),
        .code_i   (scale_code),
        .scaled_o (scaled_idx)
    );

    // Three-term adder
    ea_sum3 #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
        .base_i       (base_val),
        .base_en_i    (base_en),
        .scaled_idx_i (scaled_idx),
        .disp_i       (disp),
        .sum_o        (sum)
    );

    // Operation and legality decode
    ea_ctl_decode u_dec (
        .op_lea_i  (op_lea),
        .src_mem_i (src_mem),
        .dst_mem_i (dst_mem),
        .ctl_o     (ctl_d)
    );

    // Result register
    ea_out_stage #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .sum_i       (sum),
        .narrow_i    (op_narrow),
        .ctl_i       (ctl_d),
        .out_valid_o (out_valid),
        .ea_o        (ea_addr),
        .value_o     (wb_value),
        .ctl_o       (ctl_q)
    );

    // Unpack registered flags onto the ports
    assign mem_req = ctl_q.mem_req;
    assign wb_en   = ctl_q.wb_en;
    assign illegal = ctl_q.illegal;
endmodule

// File: rtl/ea_addr_gen_chk.sv
// Module: ea_addr_gen_chk
// Property checker for ea_addr_gen, attached with bind below.
module ea_addr_gen_chk #(
    parameter int ADDR_W   = 64,
    parameter int DISP_W   = 32,
    parameter int SCALE_W  = 2,
    parameter int NARROW_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               base_en,
    input logic [ADDR_W-1:0]  base_val,
    input logic               index_en,
    input logic [ADDR_W-1:0]  index_val,
    input logic [SCALE_W-1:0] scale_code,
    input logic [DISP_W-1:0]  disp,
    input logic               op_lea,
    input logic               op_narrow,
    input logic               src_mem,
    input logic               dst_mem,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  ea_addr,
    input logic               mem_req,
    input logic               wb_en,
    input logic [ADDR_W-1:0]  wb_value,
    input logic               illegal
);
    localparam int EXT_W = ADDR_W - DISP_W;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(mem_req || wb_en || illegal));

    // R8
    illegal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mem && dst_mem) |=> (illegal && !mem_req && !wb_en));

    // R6
    lea_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_lea) |=> !mem_req);

    // R6
    lea_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_lea && !op_narrow && !(src_mem && dst_mem)) |=> (wb_en && wb_value == ea_addr));

    // R7
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_lea && op_narrow) |=>
            (wb_value[ADDR_W-1:NARROW_W] == '0 && wb_value[NARROW_W-1:0] == ea_addr[NARROW_W-1:0]));

    // R4
    direct_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !base_en && !index_en) |=>
            (ea_addr == {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)}));
endmodule

bind ea_addr_gen ea_addr_gen_chk #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SCALE_W(SCALE_W), .NARROW_W(NARROW_W)
) u_chk (.*);

// File: tb/ea_addr_gen_tb.sv
// Bench for ea_addr_gen: sweeps forms, scales, modes and operand pairings.
module ea_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        base_en = 1'b0;
    logic [63:0] base_val = '0;
    logic        index_en = 1'b0;
    logic [63:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp = '0;
    logic        op_lea = 1'b0;
    logic        op_narrow = 1'b0;
    logic        src_mem = 1'b0;
    logic        dst_mem = 1'b0;
    logic        out_valid;
    logic [63:0] ea_addr;
    logic        mem_req;
    logic        wb_en;
    logic [63:0] wb_value;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    ea_addr_gen u_dut (.*);

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference sum, written as a multiply
    function automatic logic [63:0] ref_ea(input logic be, input logic [63:0] b,
                                           input logic ie, input logic [63:0] i,
                                           input logic [1:0] sc, input logic [31:0] d);
        logic [63:0] mult;
        mult = 64'd1 << sc;
        return (be ? b : 64'd0) + ((ie ? i : 64'd0) * mult) + {{32{d[31]}}, d};
    endfunction

    // Drive one request, then check the registered result one cycle later
    task automatic run_one(input logic be, input logic [63:0] b, input logic ie,
                           input logic [63:0] i, input logic [1:0] sc, input logic [31:0] d,
                           input logic lea, input logic nar, input logic sm, input logic dm);
        logic [63:0] e;
        logic        ill;
        string       ea_tag;
        @(negedge clk);
        in_valid = 1'b1; base_en = be; base_val = b; index_en = ie; index_val = i;
        scale_code = sc; disp = d; op_lea = lea; op_narrow = nar; src_mem = sm; dst_mem = dm;
        @(negedge clk);
        in_valid = 1'b0;
        e   = ref_ea(be, b, ie, i, sc, d);
        ill = sm & dm;
        ea_tag = d[31] ? "R5" : ((!be || !ie) ? "R4" : "R3");
        chk("R2", {63'd0, out_valid}, 64'd1);
        chk(ea_tag, ea_addr, e);
        chk(ill ? "R8" : "R6", {63'd0, mem_req}, {63'd0, !lea && !ill});
        chk(ill ? "R8" : "R6", {63'd0, wb_en}, {63'd0, lea && !ill});
        chk("R8", {63'd0, illegal}, {63'd0, ill});
        chk(nar ? "R7" : "R6", wb_value, nar ? {32'd0, e[31:0]} : e);
    endtask

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] bv [6];
        logic [63:0] iv [6];
        logic [31:0] dv [6];
        logic [63:0] x;
        bv[0] = 64'h0000_0000_0000_0200; iv[0] = 64'd2;  dv[0] = 32'd0;
        bv[1] = 64'h0000_0000_0000_0200; iv[1] = 64'd3;  dv[1] = 32'hFFFF_FFF0;
        bv[2] = 64'hFFFF_FFFF_FF00_0300; iv[2] = 64'h20; dv[2] = 32'hFFFF_FFF8;
        bv[3] = 64'h0000_0089_1234_4000; iv[3] = 64'h20; dv[3] = 32'd12;
        bv[4] = 64'hFFFF_FFFF_FFFF_FFF0; iv[4] = 64'h8000_0000_0000_0001; dv[4] = 32'h7FFF_FFFF;
        bv[5] = 64'h0000_0001_2345_6789; iv[5] = 64'h0000_0001_2345_6789; dv[5] = 32'd1;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {63'd0, out_valid}, 64'd0);
        chk("R1", {63'd0, mem_req}, 64'd0);
        chk("R1", {63'd0, wb_en}, 64'd0);
        chk("R1", {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;

        // Sweep forms, scales, modes and operand pairings
        for (int k = 0; k < 6; k++)
            for (int f = 0; f < 4; f++)
                for (int s = 0; s < 4; s++)
                    for (int m = 0; m < 4; m++)
                        for (int p = 0; p < 4; p++)
                            run_one(f[0], bv[k], f[1], iv[k], s[1:0], dv[k],
                                    m[0], m[1], p[0], p[1]);

        // R9: idle cycle after a request leaves all strobes low
        @(negedge clk);
        chk("R9", {63'd0, out_valid}, 64'd0);
        chk("R9", {63'd0, mem_req}, 64'd0);
        chk("R9", {63'd0, wb_en}, 64'd0);
        chk("R9", {63'd0, illegal}, 64'd0);

        // R7: narrow value form with 1 + x + 8x gives 9x+1 in 32 bits
        x = 64'h0000_0003_0BAD_F00D;
        run_one(1'b1, x, 1'b1, x, 2'd3, 32'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7", wb_value, {32'd0, (x * 64'd9 + 64'd1) & 64'hFFFF_FFFF});

        // R5: -16 + base + index*4
        run_one(1'b1, 64'h0000_0000_0000_0200, 1'b1, 64'd3, 2'd2, 32'hFFFF_FFF0,
                1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5", ea_addr, 64'h0000_0000_0000_01FC);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule